// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits between a CPU core and up to eight interrupting peripherals. The peripherals are wired to a serial priority chain, and chain position alone sets priority. While interrupts are enabled and no entry sequence is running, any active request raises a pending line to the CPU. When the CPU acknowledges, the controller grants exactly one device: the active requester closest to the head of the chain. That device then places its vector number on a shared vector bus.

The controller multiplies the captured vector by a power of two to form the address of a two-word table entry. It reads the new program counter from that address and the new status word from the next word, two bytes higher. It then presents both words to the CPU with a one-cycle load strobe. From the acknowledge onwards, further interrupts are masked until the CPU sends a return-from-interrupt pulse.

Requests are level signals that only the device can drop, so a request that is still active after the return is taken again. If a granted device never answers with a vector, a watchdog ends the wait after a fixed number of cycles. The controller then flags a spurious interrupt and loads the entry for a reserved vector instead.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, cpu_irq, dev_grant, mem_rd, vec_load and spurious are all 0.
- R2: While the controller is idle with interrupts enabled, any set bit of dev_req raises cpu_irq one clock later.
- R3: On cpu_ack while cpu_irq is high, dev_grant becomes one-hot on the lowest-numbered active request (bit 0 has the highest priority). dev_grant is never more than one-hot.
- R4: A clock with dev_vec_valid high while a grant is active captures dev_vec and releases dev_grant on the next clock.
- R5: The PC word is read from address vector << 1, zero-extended to 16 bits. The status word is read from that address plus 2. The PC word is read first.
- R6: new_pc and new_ps hold the two words that were read, and vec_load pulses high for exactly one clock when both are valid.
- R7: From the acknowledge until a cpu_rti pulse arrives after vec_load, cpu_irq stays low even while requests remain active.
- R8: A request still active after cpu_rti raises cpu_irq again and wins the same grant. The grant does not consume it.
- R9: If no vector arrives within 16 clocks of the grant appearing, spurious rises exactly 16 clocks after the grant appears. dev_grant is released at the same time, the entry for reserved vector 0x02 is loaded, and spurious stays high until cpu_rti.
- R10: If all requests drop before cpu_ack, cpu_irq falls and no grant is issued.
- R11: mem_rd is held and mem_addr stays stable until mem_rvalid, for any memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req | input | 8 | Level requests, bit 0 is the head of the chain |
| dev_grant | output | 8 | One-hot grant to the winning device |
| dev_vec_valid | input | 1 | Granted device is driving dev_vec |
| dev_vec | input | 8 | Vector number from the granted device |
| cpu_irq | output | 1 | Interrupt pending to the CPU |
| cpu_ack | input | 1 | CPU acknowledge |
| cpu_rti | input | 1 | Return-from-interrupt pulse, unmasks interrupts |
| mem_rd | output | 1 | Table read request |
| mem_addr | output | 16 | Table read byte address |
| mem_rdata | input | 16 | Table read data |
| mem_rvalid | input | 1 | Read data valid, completes the read |
| new_pc | output | 16 | Program counter loaded from the table |
| new_ps | output | 16 | Status word loaded from the table |
| vec_load | output | 1 | One-clock strobe: new_pc and new_ps are valid |
| spurious | output | 1 | Unanswered grant, held until return |

## Verification
If the controller picks the wrong winner, the error shows on dev_grant in the clock right after the acknowledge. An error in vector capture or scaling shows up as a wrong mem_addr on the first table read, and as wrong new_pc and new_ps values on vec_load a few clocks later. A mask that leaks, or a request that is wrongly consumed, shows on cpu_irq while a handler is running or just after the return. An off-by-one in the watchdog moves the rise of spurious by a clock, and the bench counts that clock exactly.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PEND  = 3'd1,
    ST_WAITV = 3'd2,
    ST_FPC   = 3'd3,
    ST_FPS   = 3'd4,
    ST_MASK  = 3'd5
  } irq_state_e;
endpackage

// File: rtl/irq_prio_chain.sv
module irq_prio_chain #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] req,
  output logic [N_SRC-1:0] win,
  output logic             any
);
  logic [N_SRC:0] pass;

  assign pass[0] = 1'b1;

  // each stage passes the grant on only when its own device is quiet
  for (genvar i = 0; i < N_SRC; i++) begin : g_stage
    assign win[i]    = pass[i] & req[i];
    assign pass[i+1] = pass[i] & ~req[i];
  end

  assign any = ~pass[N_SRC];
endmodule

// File: rtl/irq_timeout.sv
module irq_timeout #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = en && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en)          cnt_d = '0;
    else if (!expired) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irq_vec_fetch.sv
module irq_vec_fetch #(
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SCALE_SH = 1,
  parameter int PS_OFS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_en,
  input  logic [VEC_W-1:0]  vec_in,
  input  logic              sel_ps,
  input  logic              pc_en,
  input  logic              ps_en,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] ps
);
  localparam int PAD = ADDR_W - VEC_W;

  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] base;

  assign base = {{PAD{1'b0}}, vec_q} << SCALE_SH;
  assign addr = sel_ps ? (base + ADDR_W'(PS_OFS)) : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      pc    <= '0;
      ps    <= '0;
    end else begin
      if (vec_en) vec_q <= vec_in;
      if (pc_en)  pc    <= rdata;
      if (ps_en)  ps    <= rdata;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int              N_SRC    = 8,
  parameter int              VEC_W    = 8,
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 16,
  parameter int              SCALE_SH = 1,
  parameter int              TIMEOUT  = 16,
  parameter logic [VEC_W-1:0] SPUR_VEC = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  dev_req,
  output logic [N_SRC-1:0]  dev_grant,
  input  logic              dev_vec_valid,
  input  logic [VEC_W-1:0]  dev_vec,
  output logic              cpu_irq,
  input  logic              cpu_ack,
  input  logic              cpu_rti,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic [DATA_W-1:0] new_pc,
  output logic [DATA_W-1:0] new_ps,
  output logic              vec_load,
  output logic              spurious
);
  localparam int PS_OFS = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_state_e state_q, state_d;
  logic [N_SRC-1:0] win, grant_q, grant_d;
  logic             req_any, expired, vec_hit;
  logic             spur_q, spur_d, load_q, load_d;
  logic             vec_en, pc_en, ps_en;
  logic [VEC_W-1:0] vec_in;

  irq_prio_chain #(.N_SRC(N_SRC)) u_chain (
    .req (dev_req),
    .win (win),
    .any (req_any)
  );

  irq_timeout #(.LIMIT(TIMEOUT)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (state_q == ST_WAITV),
    .expired (expired)
  );

  assign vec_hit = (state_q == ST_WAITV) && dev_vec_valid;
  assign vec_en  = vec_hit || expired;
  assign vec_in  = dev_vec_valid ? dev_vec : SPUR_VEC;
  assign pc_en   = (state_q == ST_FPC) && mem_rvalid;
  assign ps_en   = (state_q == ST_FPS) && mem_rvalid;

  irq_vec_fetch #(
    .VEC_W    (VEC_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SCALE_SH (SCALE_SH),
    .PS_OFS   (PS_OFS)
  ) u_fetch (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .vec_en (vec_en),
    .vec_in (vec_in),
    .sel_ps (state_q == ST_FPS),
    .pc_en  (pc_en),
    .ps_en  (ps_en),
    .rdata  (mem_rdata),
    .addr   (mem_addr),
    .pc     (new_pc),
    .ps     (new_ps)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_any) state_d = ST_PEND;
      ST_PEND: begin
        if (!req_any)     state_d = ST_IDLE;
        else if (cpu_ack) state_d = ST_WAITV;
      end
      ST_WAITV: if (vec_en) state_d = ST_FPC;
      ST_FPC:   if (mem_rvalid) state_d = ST_FPS;
      ST_FPS:   if (mem_rvalid) state_d = ST_MASK;
      ST_MASK:  if (cpu_rti) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    grant_d = '0;
    if (state_q == ST_PEND && req_any && cpu_ack) grant_d = win;
    else if (state_q == ST_WAITV && !vec_en)      grant_d = grant_q;
  end

  always_comb begin
    spur_d = spur_q;
    if (state_q == ST_WAITV && expired && !dev_vec_valid) spur_d = 1'b1;
    else if (state_q == ST_MASK && cpu_rti)               spur_d = 1'b0;
  end

  assign load_d = ps_en;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      grant_q <= '0;
      spur_q  <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
      spur_q  <= spur_d;
      load_q  <= load_d;
    end
  end

  assign dev_grant = grant_q;
  assign cpu_irq   = (state_q == ST_PEND);
  assign mem_rd    = (state_q == ST_FPC) || (state_q == ST_FPS);
  assign vec_load  = load_q;
  assign spurious  = spur_q;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:0]  dev_req,
  input logic [N_SRC-1:0]  dev_grant,
  input logic              dev_vec_valid,
  input logic              cpu_irq,
  input logic              cpu_ack,
  input logic              cpu_rti,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              vec_load,
  input logic              spurious
);
  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));

  assert_ack_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_ack && (dev_req != '0)) |=> (dev_grant != '0));

  assert_grant_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_grant != '0) |-> !cpu_irq);

  assert_load_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (!cpu_irq && !mem_rd));

  assert_load_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |=> !vec_load);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

  assert_spur_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spurious) |-> ($past(dev_grant) != '0 && !$past(dev_vec_valid)));

  assert_spur_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spurious) |-> $past(cpu_rti));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .dev_req       (dev_req),
  .dev_grant     (dev_grant),
  .dev_vec_valid (dev_vec_valid),
  .cpu_irq       (cpu_irq),
  .cpu_ack       (cpu_ack),
  .cpu_rti       (cpu_rti),
  .mem_rd        (mem_rd),
  .mem_addr      (mem_addr),
  .mem_rvalid    (mem_rvalid),
  .vec_load      (vec_load),
  .spurious      (spurious)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  localparam int NROW = 8;
  localparam logic [7:0] ROW_REQ [NROW] = '{8'b0000_0001, 8'b1000_0000, 8'b1010_0100,
    8'b1111_1111, 8'b0110_0000, 8'b0001_1000, 8'b1100_0000, 8'b0000_0010};
  localparam int ROW_WIN [NROW] = '{0, 7, 2, 0, 5, 3, 6, 1};
  localparam int ROW_LAT [NROW] = '{0, 1, 0, 2, 3, 0, 1, 0};

  logic        clk, rst_n;
  logic [7:0]  dev_req, dev_grant, dev_vec;
  logic        dev_vec_valid, cpu_irq, cpu_ack, cpu_rti;
  logic        mem_rd, mem_rvalid, vec_load, spurious;
  logic [15:0] mem_addr, mem_rdata, new_pc, new_ps;
  logic [3:0]  mem_lat, wcnt;

  int n_chk = 0;
  int n_bad = 0;

  vec_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_grant(dev_grant),
    .dev_vec_valid(dev_vec_valid), .dev_vec(dev_vec), .cpu_irq(cpu_irq),
    .cpu_ack(cpu_ack), .cpu_rti(cpu_rti), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .new_pc(new_pc),
    .new_ps(new_ps), .vec_load(vec_load), .spurious(spurious)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // table memory model with programmable latency
  assign mem_rvalid = mem_rd && (wcnt == mem_lat);
  assign mem_rdata  = mem_addr ^ 16'hA5C3;
  always_ff @(posedge clk) begin
    if (!mem_rd || mem_rvalid) wcnt <= '0;
    else                       wcnt <= wcnt + 4'd1;
  end

  function automatic logic [7:0] vec_of(int i);
    return 8'h40 + 8'(i * 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_irq(output bit seen);
    seen = 0;
    for (int k = 0; k < 4 && !seen; k++) begin
      @(negedge clk);
      seen = cpu_irq;
    end
  endtask

  task automatic wait_load(output bit seen);
    seen = 0;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(negedge clk);
      seen = vec_load;
    end
  endtask

  // one full entry: request, acknowledge, vector (or none), table fetch
  task automatic serve(logic [7:0] req, int win, int lat, bit answer);
    bit seen;
    logic [7:0]  v;
    logic [15:0] base;
    mem_lat = 4'(lat);
    dev_req = req;
    wait_irq(seen);
    check("R2 irq on request", 32'(seen), 32'd1);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    check("R3 grant winner", 32'(dev_grant), 32'(8'(1) << win));
    check("R7 irq low once granted", 32'(cpu_irq), 32'd0);
    if (answer) begin
      v = vec_of(win);
      dev_vec = v;
      dev_vec_valid = 1'b1;
      @(negedge clk);
      dev_vec_valid = 1'b0;
      check("R4 grant released", 32'(dev_grant), 32'd0);
    end else begin
      v = 8'h02;
      for (int k = 1; k < 16; k++) @(negedge clk);
      check("R9 no spurious before 16", 32'(spurious), 32'd0);
      @(negedge clk);
      check("R9 spurious at 16", 32'(spurious), 32'd1);
      check("R9 grant released", 32'(dev_grant), 32'd0);
    end
    base = {8'h00, v} << 1;
    wait_load(seen);
    check("R6 vec_load seen", 32'(seen), 32'd1);
    check("R5 new_pc from vector<<1", 32'(new_pc), 32'(base ^ 16'hA5C3));
    check("R5 new_ps from vector<<1 plus 2", 32'(new_ps), 32'((base + 16'd2) ^ 16'hA5C3));
    @(negedge clk);
    check("R6 vec_load one clock", 32'(vec_load), 32'd0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    check("R7 masked with request held", 32'(cpu_irq), 32'd0);
    if (!answer) check("R9 spurious held", 32'(spurious), 32'd1);
  endtask

  task automatic do_rti();
    cpu_rti = 1'b1;
    @(negedge clk);
    cpu_rti = 1'b0;
  endtask

  initial begin : watchdog
    for (int k = 0; k < 100000; k++) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    bit seen;
    rst_n = 1'b0;
    dev_req = '0; dev_vec = '0; dev_vec_valid = 1'b0;
    cpu_ack = 1'b0; cpu_rti = 1'b0; mem_lat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 irq", 32'(cpu_irq), 32'd0);
    check("R1 grant", 32'(dev_grant), 32'd0);
    check("R1 mem_rd", 32'(mem_rd), 32'd0);
    check("R1 vec_load", 32'(vec_load), 32'd0);
    check("R1 spurious", 32'(spurious), 32'd0);

    for (int r = 0; r < NROW; r++) begin
      serve(ROW_REQ[r], ROW_WIN[r], ROW_LAT[r], 1'b1);
      check("R11 memory latency row done", 32'(mem_rd), 32'd0);
      dev_req = '0;
      do_rti();
      @(negedge clk);
      check("R7 idle after return", 32'(cpu_irq), 32'd0);
    end

    // R10: request withdrawn before acknowledge
    dev_req = 8'b0000_1000;
    wait_irq(seen);
    dev_req = '0;
    @(negedge clk);
    check("R10 irq drops", 32'(cpu_irq), 32'd0);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    check("R10 no grant", 32'(dev_grant), 32'd0);

    // R8: level-held request is taken again after return
    serve(8'b0001_0000, 4, 0, 1'b1);
    do_rti();
    serve(8'b0001_0000, 4, 2, 1'b1);
    check("R8 same winner again", 32'(new_pc), 32'((16'(vec_of(4)) << 1) ^ 16'hA5C3));
    dev_req = '0;
    do_rti();

    // R9: unanswered grant
    serve(8'b0100_0100, 2, 1, 1'b0);
    dev_req = '0;
    do_rti();
    @(negedge clk);
    check("R9 spurious cleared by return", 32'(spurious), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule